// File: doc/BRIEF.md
# Bus Error Status and Interrupt Register

This block captures error events reported by a host bridge into sticky status flags that software can read. The four error classes are address bus time-out, PCI system error, signalled master abort and received target abort. A fifth flag records overflow: it sets when a new error arrives while an earlier error flag is still pending. Software clears any flag by writing a 1 to its bit. Writing a 0 to a bit leaves that flag alone.

The three PCI error classes each have an interrupt enable bit in a separate control word. The block drives one level-sensitive interrupt request to an external interrupt controller. That request is the OR of every PCI error flag whose enable is set. Software reaches both words through a register port with byte-lane write strobes. Reads are combinational and have no side effects.

Register layout: the control word is at byte offset 0x0 and the status word is at 0x4. The two low address bits are ignored. All other word offsets read 0 and ignore writes. Every implemented bit lives in byte lane 0, so a write changes a bit only when `reg_wstrb[0]` is 1.
- Control word bits: bit 0 is the system-error interrupt enable, bit 1 the master-abort interrupt enable, bit 2 the target-abort interrupt enable.
- Status word bits: bit 0 is the time-out flag, bit 1 the system-error flag, bit 2 the master-abort flag, bit 3 the target-abort flag, bit 7 the overflow flag.

Top module: `bus_err_status_top`

## Requirements
- R1: After a synchronous active-low reset, the status word, the control word and `irq_req` are all 0.
- R2: An error input that is high in a cycle sets its status flag (bit 0 time-out, bit 1 system error, bit 2 master abort, bit 3 target abort) at that clock edge. The flag then stays set in later cycles until it is cleared.
- R3: A write to the status word with `reg_wstrb[0]`=1 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. A write with `reg_wstrb[0]`=0 changes no flag.
- R4: If any error input is high in a cycle where at least one of status bits 0..3 is already set, overflow (status bit 7) sets at that edge.
- R5: Errors that arrive while status bits 0..3 are all clear set only their own flags and never set overflow. This holds when several such errors arrive in the same cycle.
- R6: Overflow is cleared by writing 1 to status bit 7 with `reg_wstrb[0]`=1. Other flags are untouched unless their own bits are written as 1.
- R7: If an error event and a clearing write for the same flag occur in the same cycle, the flag ends up set.
- R8: `irq_req` is high exactly when at least one of these pairs is active: system-error flag with control bit 0, master-abort flag with control bit 1, target-abort flag with control bit 2. The time-out flag and the overflow flag never drive `irq_req`.
- R9: `irq_req` falls in the cycle that follows the write that clears the last enabled, set PCI error flag.
- R10: Control bits 2..0 are read/write and are written only when `reg_wstrb[0]`=1.
- R11: Unused bits of both words, and every word offset other than 0x0 and 0x4, read as 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write request for this cycle |
| reg_addr | input | ADDR_W (4) | Byte address of the register access |
| reg_wstrb | input | DATA_W/8 (4) | Byte-lane write strobes |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| evt_addr_timeout | input | 1 | Expiry pulse from the external address bus timer |
| evt_sys_err | input | 1 | PCI system error detected |
| evt_mst_abort | input | 1 | Bridge signalled a master abort |
| evt_tgt_abort | input | 1 | Bridge received a target abort |
| irq_req | output | 1 | Level interrupt request to the interrupt controller |

## Verification
The checker evaluates the following on every cycle: each flag's set-on-event rule with priority over clearing, stickiness while no clearing write is present, write-one-to-clear, the overflow set condition and its only legal cause, and the two directions of the enable gating on the interrupt. Other properties depend on addressing and the chosen layout, and only the bench's scenarios show them. These are that data bits written as 0 and writes on other byte lanes leave flags alone, that enable bits read back through the control word, that unused bits and offsets read 0 and ignore writes, and the exact cycle in which the interrupt falls after a clear.

// File: rtl/bus_err_pkg.sv
// Package: shared constants for the bus error status register.
// Assumes: one bit per error class, indexed as below; the status word
// also keeps the overflow flag at OVF_BIT.
package bus_err_pkg;

    localparam int unsigned ERR_W   = 4;   // number of error classes
    localparam int unsigned EN_W    = 3;   // number of interrupt enables
    localparam int unsigned OVF_BIT = 7;   // overflow position in status word

    // Bit position of each error class in the status word.
    typedef enum int unsigned {
        ERR_TMO  = 0,
        ERR_SERR = 1,
        ERR_MABT = 2,
        ERR_TABT = 3
    } err_idx_e;

    // Error classes that may drive the interrupt (time-out may not).
    localparam logic [ERR_W-1:0] IRQ_CAPABLE = 4'b1110;

    // Word offsets (byte address >> 2).
    localparam int unsigned CTRL_WORD = 0;
    localparam int unsigned STAT_WORD = 1;

endpackage

// File: rtl/bus_err_flag_bank.sv
// Module: bus_err_flag_bank
// One sticky flag per error class. A flag sets on its event and clears
// on its clear request. Set has priority, so an error arriving in the
// same cycle as a clear survives.
// Assumes: events are single-cycle or level, and are synchronous to clk.
module bus_err_flag_bank #(
    parameter int unsigned ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_evt,
    input  logic [ERR_W-1:0] clr_mask,
    output logic [ERR_W-1:0] flags
);

    for (genvar g = 0; g < ERR_W; g++) begin : g_flag
        // Purpose: hold one sticky flag with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (err_evt[g]) begin
                flags[g] <= 1'b1;
            end else if (clr_mask[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bus_err_ovf.sv
// Module: bus_err_ovf
// Overflow tracker. It sets when any event arrives while any error flag
// is already set, judged from the flag values before this edge. It
// clears on request, and a new overflow condition wins over the clear.
// Assumes: flags are the registered outputs of the flag bank.
module bus_err_ovf #(
    parameter int unsigned ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_evt,
    input  logic [ERR_W-1:0] flags,
    input  logic             ovf_clr,
    output logic             ovf
);

    logic any_evt;
    logic any_pending;
    logic ovf_hit;

    // Purpose: detect a new error landing on a pending one.
    always_comb begin
        any_evt     = |err_evt;
        any_pending = |flags;
        ovf_hit     = any_evt && any_pending;
    end

    // Purpose: hold the overflow flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (ovf_hit) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/bus_err_irq.sv
// Module: bus_err_irq
// Interrupt gating. Each interrupt-capable flag is ANDed with its
// enable, and the results are ORed into one level request. Classes
// outside CAPABLE are masked off.
// Assumes: en is aligned bit for bit with flags (non-capable bits unused).
module bus_err_irq #(
    parameter int unsigned      ERR_W   = 4,
    parameter logic [ERR_W-1:0] CAPABLE = '1
) (
    input  logic [ERR_W-1:0] flags,
    input  logic [ERR_W-1:0] en,
    output logic             irq
);

    logic [ERR_W-1:0] gated;

    for (genvar g = 0; g < ERR_W; g++) begin : g_gate
        if (CAPABLE[g]) begin : g_on
            // Purpose: pass this flag when its enable is set.
            always_comb gated[g] = flags[g] & en[g];
        end else begin : g_off
            // Purpose: this class never interrupts.
            always_comb gated[g] = 1'b0;
        end
    end

    // Purpose: merge every gated flag into the request line.
    always_comb irq = |gated;

endmodule

// File: rtl/bus_err_regif.sv
// Module: bus_err_regif
// Register port. It decodes the word address, holds the enable bits,
// turns status writes into per-flag clear requests, and builds the
// read data.
// Assumes: every implemented bit sits below DATA_W; byte strobes gate
// every bit of their lane; reads have no side effects.
module bus_err_regif #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ERR_W   = 4,
    parameter int unsigned EN_W    = 3,
    parameter int unsigned OVF_BIT = 7,
    parameter int unsigned CTRL_WD = 0,
    parameter int unsigned STAT_WD = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [ERR_W-1:0]    flags,
    input  logic                ovf,
    output logic [EN_W-1:0]     en,
    output logic [ERR_W-1:0]    clr_mask,
    output logic                ovf_clr,
    output logic [DATA_W-1:0]   rdata
);

    localparam int unsigned STRB_W = DATA_W / 8;
    localparam int unsigned WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] CTRL_IDX = WIDX_W'(CTRL_WD);
    localparam logic [WIDX_W-1:0] STAT_IDX = WIDX_W'(STAT_WD);

    logic [WIDX_W-1:0] word_idx;
    logic              sel_ctrl;
    logic              sel_stat;
    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] wr_ones;

    // Purpose: widen each byte strobe to a mask over its eight bits.
    for (genvar b = 0; b < STRB_W; b++) begin : g_lane
        always_comb bit_mask[b*8 +: 8] = {8{wstrb[b]}};
    end

    // Purpose: decode which word the access targets.
    always_comb begin
        word_idx = addr[ADDR_W-1:2];
        sel_ctrl = (word_idx == CTRL_IDX);
        sel_stat = (word_idx == STAT_IDX);
        wr_ones  = wdata & bit_mask;
    end

    // Purpose: turn a status write into clear requests for the flags
    // whose written bits are 1.
    always_comb begin
        clr_mask = (wr_en && sel_stat) ? wr_ones[ERR_W-1:0] : '0;
        ovf_clr  = wr_en && sel_stat && wr_ones[OVF_BIT];
    end

    // Purpose: update the enable bits in the lanes whose strobes are set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr_en && sel_ctrl) begin
            en <= (en & ~bit_mask[EN_W-1:0]) | wr_ones[EN_W-1:0];
        end
    end

    // Purpose: build the read data; unused bits and words return 0.
    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[EN_W-1:0] = en;
        end else if (sel_stat) begin
            rdata[ERR_W-1:0] = flags;
            rdata[OVF_BIT]   = ovf;
        end
    end

endmodule

// File: rtl/bus_err_status_top.sv
// Module: bus_err_status_top
// Bus error status and interrupt register for a host bridge. It
// captures four error classes into sticky write-one-to-clear flags,
// tracks overflow, and gates the PCI classes onto one level interrupt
// through per-class enables.
// Assumes: error inputs are synchronous to clk; the time-out counter and
// the interrupt controller are outside this block.
module bus_err_status_top #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W/8-1:0] reg_wstrb,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                evt_addr_timeout,
    input  logic                evt_sys_err,
    input  logic                evt_mst_abort,
    input  logic                evt_tgt_abort,
    output logic                irq_req
);

    import bus_err_pkg::*;

    logic [ERR_W-1:0] err_evt;
    logic [ERR_W-1:0] err_flags;
    logic [ERR_W-1:0] clr_mask;
    logic [EN_W-1:0]  irq_en;
    logic [ERR_W-1:0] irq_en_al;
    logic             ovf_flag;
    logic             ovf_clr;

    // Purpose: gather the error inputs by status bit position.
    always_comb begin
        err_evt           = '0;
        err_evt[ERR_TMO]  = evt_addr_timeout;
        err_evt[ERR_SERR] = evt_sys_err;
        err_evt[ERR_MABT] = evt_mst_abort;
        err_evt[ERR_TABT] = evt_tgt_abort;
    end

    // Purpose: line the enables up with the flags they gate.
    always_comb begin
        irq_en_al           = '0;
        irq_en_al[ERR_SERR] = irq_en[0];
        irq_en_al[ERR_MABT] = irq_en[1];
        irq_en_al[ERR_TABT] = irq_en[2];
    end

    bus_err_regif #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ERR_W   (ERR_W),
        .EN_W    (EN_W),
        .OVF_BIT (OVF_BIT),
        .CTRL_WD (CTRL_WORD),
        .STAT_WD (STAT_WORD)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wstrb    (reg_wstrb),
        .wdata    (reg_wdata),
        .flags    (err_flags),
        .ovf      (ovf_flag),
        .en       (irq_en),
        .clr_mask (clr_mask),
        .ovf_clr  (ovf_clr),
        .rdata    (reg_rdata)
    );

    bus_err_flag_bank #(
        .ERR_W (ERR_W)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_evt  (err_evt),
        .clr_mask (clr_mask),
        .flags    (err_flags)
    );

    bus_err_ovf #(
        .ERR_W (ERR_W)
    ) u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_evt (err_evt),
        .flags   (err_flags),
        .ovf_clr (ovf_clr),
        .ovf     (ovf_flag)
    );

    bus_err_irq #(
        .ERR_W   (ERR_W),
        .CAPABLE (IRQ_CAPABLE)
    ) u_irq (
        .flags (err_flags),
        .en    (irq_en_al),
        .irq   (irq_req)
    );

endmodule

// File: rtl/bus_err_status_chk.sv
// Module: bus_err_status_chk
// Protocol checker for bus_err_status_top, attached by bind. It relates
// the port-level events and writes to the flag, overflow, enable and
// interrupt state on every cycle.
// Assumes: status word at word index 1, all flags in byte lane 0.
module bus_err_status_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W/8-1:0] wstrb,
    input logic [DATA_W-1:0]   wdata,
    input logic [3:0]          evt,
    input logic [3:0]          flags,
    input logic                ovf,
    input logic [2:0]          en,
    input logic                irq
);

    logic       stat_wr;
    logic [3:0] clr_req;
    logic [2:0] pci_on;

    // Purpose: derive per-flag clear requests from the port activity.
    always_comb begin
        stat_wr = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(1)) && wstrb[0];
        clr_req = stat_wr ? wdata[3:0] : 4'b0;
        pci_on  = flags[3:1] & en;
    end

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (flags == 4'b0 && !ovf && en == 3'b0)); // R1

    for (genvar i = 0; i < 4; i++) begin : g_flag_chk
        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) evt[i] |=> flags[i]); // R7
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flags[i] && !clr_req[i]) |=> flags[i]); // R2
        AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (flags[i] && clr_req[i] && !evt[i]) |=> !flags[i]); // R3
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) ((|evt) && (|flags)) |=> ovf); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> $past((|evt) && (|flags))); // R5
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (|pci_on)); // R8
    AST_IRQ_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) (|pci_on) |-> irq); // R8

endmodule

bind bus_err_status_top bus_err_status_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wstrb (reg_wstrb),
    .wdata (reg_wdata),
    .evt   ({evt_tgt_abort, evt_mst_abort, evt_sys_err, evt_addr_timeout}),
    .flags (err_flags),
    .ovf   (ovf_flag),
    .en    (irq_en),
    .irq   (irq_req)
);

// File: tb/bus_err_status_top_tb.sv
// Directed bench for bus_err_status_top: one task per scenario.
module bus_err_status_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [3:0]  reg_wstrb = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_addr_timeout = 1'b0;
    logic        evt_sys_err = 1'b0;
    logic        evt_mst_abort = 1'b0;
    logic        evt_tgt_abort = 1'b0;
    logic        irq_req;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;

    bus_err_status_top u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_wr_en        (reg_wr_en),
        .reg_addr         (reg_addr),
        .reg_wstrb        (reg_wstrb),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .evt_addr_timeout (evt_addr_timeout),
        .evt_sys_err      (evt_sys_err),
        .evt_mst_abort    (evt_mst_abort),
        .evt_tgt_abort    (evt_tgt_abort),
        .irq_req          (irq_req)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] s, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wstrb = s; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0; reg_wstrb = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] ev);
        {evt_tgt_abort, evt_mst_abort, evt_sys_err, evt_addr_timeout} = ev;
        tick();
        {evt_tgt_abort, evt_mst_abort, evt_sys_err, evt_addr_timeout} = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
        rd(A_STAT, d); check("R1 stat", d, 32'h0);
        check("R1 irq", {31'b0, irq_req}, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(4'b0001);
        rd(A_STAT, d); check("R2 timeout set", d, 32'h01);
        repeat (3) tick();
        rd(A_STAT, d); check("R2 sticky", d, 32'h01);
        wr(A_STAT, 4'h1, 32'h01);
        rd(A_STAT, d); check("R3 clear timeout", d, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse(4'b0110);
        rd(A_STAT, d); check("R5 two errors no ovf", d, 32'h06);
        wr(A_STAT, 4'h1, 32'h0);
        rd(A_STAT, d); check("R3 zero bits keep", d, 32'h06);
        wr(A_STAT, 4'hE, 32'h0606_0606);
        rd(A_STAT, d); check("R3 lane0 strobe off", d, 32'h06);
        wr(A_STAT, 4'h1, 32'h02);
        rd(A_STAT, d); check("R3 clear one of two", d, 32'h04);
        wr(A_STAT, 4'h1, 32'h04);
        rd(A_STAT, d); check("R3 clear last", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        pulse(4'b1000);
        pulse(4'b0001);
        rd(A_STAT, d); check("R4 overflow set", d, 32'h89);
        wr(A_STAT, 4'h1, 32'h80);
        rd(A_STAT, d); check("R6 clear ovf only", d, 32'h09);
        wr(A_STAT, 4'h1, 32'h09);
        rd(A_STAT, d); check("R6 all clear", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(4'b0100);
        evt_mst_abort = 1'b1;
        wr(A_STAT, 4'h1, 32'h04);
        evt_mst_abort = 1'b0;
        rd(A_STAT, d); check("R7 set beats clear", d, 32'h84);
        wr(A_STAT, 4'h1, 32'h84);
        rd(A_STAT, d); check("R7 cleanup", d, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(A_CTRL, 4'h1, 32'h07);
        rd(A_CTRL, d); check("R10 enables readback", d, 32'h07);
        pulse(4'b0001);
        check("R8 timeout no irq", {31'b0, irq_req}, 32'h0);
        wr(A_CTRL, 4'h1, 32'h00);
        pulse(4'b0010);
        rd(A_STAT, d); check("R4 ovf via serr", d, 32'h83);
        check("R8 serr disabled", {31'b0, irq_req}, 32'h0);
        wr(A_CTRL, 4'h1, 32'h01);
        check("R8 serr enabled", {31'b0, irq_req}, 32'h1);
        wr(A_CTRL, 4'h1, 32'h02);
        check("R8 wrong enable", {31'b0, irq_req}, 32'h0);
        pulse(4'b0100);
        check("R8 mabt enabled", {31'b0, irq_req}, 32'h1);
        wr(A_STAT, 4'h1, 32'h04);
        check("R9 irq falls after clear", {31'b0, irq_req}, 32'h0);
        rd(A_STAT, d); check("R9 others remain", d, 32'h83);
        wr(A_STAT, 4'h1, 32'h8F);
        wr(A_CTRL, 4'h1, 32'h00);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        wr(A_CTRL, 4'hF, 32'hFFFF_FFFF);
        rd(A_CTRL, d); check("R11 unused ctrl bits", d, 32'h07);
        wr(A_CTRL, 4'hE, 32'h0);
        rd(A_CTRL, d); check("R10 strobe off keeps", d, 32'h07);
        wr(4'h8, 4'hF, 32'hFFFF_FFFF);
        rd(4'h8, d); check("R11 unused word 8", d, 32'h0);
        rd(4'hC, d); check("R11 unused word C", d, 32'h0);
        rd(A_CTRL, d); check("R11 no alias write", d, 32'h07);
        rd(A_STAT, d); check("R11 stat untouched", d, 32'h0);
        wr(A_CTRL, 4'h1, 32'h0);
        rd(A_CTRL, d); check("R10 clear enables", d, 32'h0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_sticky();
        t_w1c();
        t_overflow();
        t_set_wins();
        t_irq();
        t_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule